// File: doc/BRIEF.md
# Peripheral Protection Permission Register Bank

This block stores the security and privilege settings for a set of peripheral protection controllers. The controllers are organised in three groups: internal APB, APB expansion and AHB expansion. Each port of each controller has a non-secure enable bit and two privilege mask bits. The block drives those settings out continuously to the downstream controllers, which do the actual access checks.

Software reaches the bank through two 32-bit APB-style register windows. The secure window writes the per-port non-secure enables, the secure-side privilege masks and two configuration fields. The non-secure window writes only the non-secure-side privilege masks, and it uses the same offsets the secure window uses for its privilege masks.

For every port the block drives a non-secure indication and a privileged-access indication. The privileged-access indication comes from one of the two masks, chosen by that port's security bit. Accesses always complete in the access phase, with no wait states and no error response.

Top module: `ppc_perm_bank`

## Requirements
- R1: Controller `i` (0..3) of a group is addressed at group base + 4*i, so address bits [3:2] pick the index. The bases are:
  - non-secure enables (secure window): AHB expansion 0x60, internal APB 0x70, APB expansion 0x80.
  - privilege masks (both windows): AHB expansion 0xA0, internal APB 0xB0, APB expansion 0xC0.
  An index at or above the group's controller count is unmapped.
- R2: A secure word write to a non-secure enable register stores only the low bits up to that controller's port count. Stored bit k drives the non-secure output of port k on the clock edge that ends the access.
- R3: For each port, the privileged output equals the non-secure-side mask bit when the port's non-secure bit is 1, and the secure-side mask bit when it is 0. It follows any change of the three registers in the same cycle that register changes.
- R4: At the privilege-mask offsets, the secure window reads and writes the secure-side mask and the non-secure window reads and writes the non-secure-side mask. Each mask is masked to the port count. The non-secure window cannot reach the non-secure enables or the configuration fields.
- R5: Only word writes take effect. A word write has size code 2 and address bits [1:0] = 0. A write with size code 0 (byte), 1 (halfword) or 3, or a word write to an unaligned address, changes nothing.
- R6: Reads ignore address bits [1:0] when selecting the register. The addressed word is then shifted right by 8*addr[1:0]. Size code 0 returns the low 8 bits of the result, size code 1 returns the low 16 bits, and size codes 2 and 3 return the whole word, all zero-extended.
- R7: The response-configuration field at secure offset 0x10 keeps write bit 0. The non-secure-callable field at secure offset 0x14 keeps bits [1:0]. Both drive their outputs continuously and read back in the same bits.
- R8: The internal AHB controller slots at 0x50 and 0x90 read as zero and ignore writes in both windows.
- R9: Reset clears all non-secure enables, both privilege masks and both configuration fields, so every output reads zero.
- R10: Unmapped offsets read as zero and ignore writes. pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_psel_i | input | 1 | Secure window select |
| s_penable_i | input | 1 | Secure window access phase |
| s_pwrite_i | input | 1 | Secure window write |
| s_paddr_i | input | AW | Secure window byte address |
| s_psize_i | input | 2 | Secure access size code (0 byte, 1 half, 2 word) |
| s_pwdata_i | input | 32 | Secure write data |
| s_prdata_o | output | 32 | Secure read data |
| s_pready_o | output | 1 | Secure ready, always 1 |
| s_pslverr_o | output | 1 | Secure error, always 0 |
| ns_psel_i | input | 1 | Non-secure window select |
| ns_penable_i | input | 1 | Non-secure window access phase |
| ns_pwrite_i | input | 1 | Non-secure window write |
| ns_paddr_i | input | AW | Non-secure window byte address |
| ns_psize_i | input | 2 | Non-secure access size code |
| ns_pwdata_i | input | 32 | Non-secure write data |
| ns_prdata_o | output | 32 | Non-secure read data |
| ns_pready_o | output | 1 | Non-secure ready, always 1 |
| ns_pslverr_o | output | 1 | Non-secure error, always 0 |
| apb_nonsec_o | output | APB_CNT*APB_PORTS | Internal APB per-port non-secure indication |
| apb_priv_o | output | APB_CNT*APB_PORTS | Internal APB per-port privileged indication |
| apbx_nonsec_o | output | APBX_CNT*APBX_PORTS | APB expansion non-secure indication |
| apbx_priv_o | output | APBX_CNT*APBX_PORTS | APB expansion privileged indication |
| ahbx_nonsec_o | output | AHBX_CNT*AHBX_PORTS | AHB expansion non-secure indication |
| ahbx_priv_o | output | AHBX_CNT*AHBX_PORTS | AHB expansion privileged indication |
| resp_cfg_o | output | 1 | Response configuration bit |
| nsc_cfg_o | output | 2 | Non-secure-callable configuration |

## Verification
Directed cases first set all non-secure bits, then a mix of non-secure bits, with different patterns in the two masks. This shows whether each port's privileged output follows the correct mask rather than a fixed one. Cross-window writes at shared offsets show whether the two windows reach separate storage. Writes of all ones to ports above the port count show whether the stored value is masked to the port count. Out-of-range indices show whether the decoder aliases an absent controller onto a present one. Random mixed-size, mixed-window traffic, including unaligned and unmapped addresses, is compared against a bench model for every read lane and for every output after each access. A reset in the middle of the run confirms that all state clears.

// File: rtl/ppc_perm_pkg.sv
package ppc_perm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // 16-byte slot numbers (address bits above [3:0])
  localparam logic [7:0] SLOT_AHBX_NS = 8'h06;
  localparam logic [7:0] SLOT_APB_NS  = 8'h07;
  localparam logic [7:0] SLOT_APBX_NS = 8'h08;
  localparam logic [7:0] SLOT_AHBX_PV = 8'h0A;
  localparam logic [7:0] SLOT_APB_PV  = 8'h0B;
  localparam logic [7:0] SLOT_APBX_PV = 8'h0C;

  localparam int unsigned OFS_RESP = 'h10;
  localparam int unsigned OFS_NSC  = 'h14;

  function automatic logic [31:0] lane_pick(input logic [31:0] w,
                                            input logic [1:0]  a,
                                            input logic [1:0]  sz);
    logic [31:0] sh;
    sh = w >> {a, 3'b000};
    case (sz)
      2'd0:    return {24'd0, sh[7:0]};
      2'd1:    return {16'd0, sh[15:0]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/ppc_ctrl.sv
module ppc_ctrl #(
  parameter int unsigned P = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ns_we_i,
  input  logic         sp_we_i,
  input  logic         nsp_we_i,
  input  logic [P-1:0] s_wdata_i,
  input  logic [P-1:0] ns_wdata_i,
  output logic [P-1:0] ns_q_o,
  output logic [P-1:0] sp_q_o,
  output logic [P-1:0] nsp_q_o,
  output logic [P-1:0] nonsec_o,
  output logic [P-1:0] priv_o
);

  logic [P-1:0] ns_q, sp_q, nsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else begin
      if (ns_we_i)  ns_q  <= s_wdata_i;
      if (sp_we_i)  sp_q  <= s_wdata_i;
      if (nsp_we_i) nsp_q <= ns_wdata_i;
    end
  end

  for (genvar i = 0; i < P; i++) begin : g_port
    assign priv_o[i] = ns_q[i] ? nsp_q[i] : sp_q[i];
  end

  assign nonsec_o = ns_q;
  assign ns_q_o   = ns_q;
  assign sp_q_o   = sp_q;
  assign nsp_q_o  = nsp_q;

  p_ns_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_we_i |=> nonsec_o == $past(s_wdata_i));

  p_nsp_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nsp_we_i |=> nsp_q_o == $past(ns_wdata_i));

  p_priv_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ns_we_i && !sp_we_i && !nsp_we_i) |=> $stable(priv_o));

endmodule

// File: rtl/ppc_group.sv
module ppc_group #(
  parameter int unsigned N       = 4,
  parameter int unsigned P       = 16,
  parameter int unsigned AW      = 12,
  parameter logic [7:0]  NS_SLOT = 8'h08,
  parameter logic [7:0]  PV_SLOT = 8'h0C
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           s_we_i,
  input  logic [AW-1:0]  s_addr_i,
  input  logic [31:0]    s_wdata_i,
  input  logic           ns_we_i,
  input  logic [AW-1:0]  ns_addr_i,
  input  logic [31:0]    ns_wdata_i,
  output logic [31:0]    s_rdata_o,
  output logic [31:0]    ns_rdata_o,
  output logic [N*P-1:0] nonsec_o,
  output logic [N*P-1:0] priv_o
);

  localparam int unsigned SW = AW - 4;

  logic         s_ns_slot, s_pv_slot, ns_pv_slot;
  logic [1:0]   s_idx, ns_idx;
  logic [P-1:0] ns_q  [N];
  logic [P-1:0] sp_q  [N];
  logic [P-1:0] nsp_q [N];

  assign s_idx      = s_addr_i[3:2];
  assign ns_idx     = ns_addr_i[3:2];
  assign s_ns_slot  = s_addr_i[AW-1:4]  == SW'(NS_SLOT);
  assign s_pv_slot  = s_addr_i[AW-1:4]  == SW'(PV_SLOT);
  assign ns_pv_slot = ns_addr_i[AW-1:4] == SW'(PV_SLOT);

  for (genvar c = 0; c < N; c++) begin : g_ctrl
    logic s_sel, ns_sel;
    assign s_sel  = s_idx == 2'(c);
    assign ns_sel = ns_idx == 2'(c);

    ppc_ctrl #(.P(P)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ns_we_i    (s_we_i & s_ns_slot & s_sel),
      .sp_we_i    (s_we_i & s_pv_slot & s_sel),
      .nsp_we_i   (ns_we_i & ns_pv_slot & ns_sel),
      .s_wdata_i  (s_wdata_i[P-1:0]),
      .ns_wdata_i (ns_wdata_i[P-1:0]),
      .ns_q_o     (ns_q[c]),
      .sp_q_o     (sp_q[c]),
      .nsp_q_o    (nsp_q[c]),
      .nonsec_o   (nonsec_o[c*P +: P]),
      .priv_o     (priv_o[c*P +: P])
    );
  end

  // absent indices fall through to zero
  always_comb begin
    s_rdata_o  = '0;
    ns_rdata_o = '0;
    for (int c = 0; c < N; c++) begin
      if (s_idx == 2'(c)) begin
        if (s_ns_slot) s_rdata_o = 32'(ns_q[c]);
        if (s_pv_slot) s_rdata_o = 32'(sp_q[c]);
      end
      if (ns_idx == 2'(c) && ns_pv_slot) ns_rdata_o = 32'(nsp_q[c]);
    end
  end

  logic unused_bits;
  assign unused_bits = ^{s_wdata_i, ns_wdata_i, s_addr_i[1:0], ns_addr_i[1:0]};

endmodule

// File: rtl/ppc_perm_bank.sv
module ppc_perm_bank
  import ppc_perm_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned APB_CNT    = 2,
  parameter int unsigned APB_PORTS  = 4,
  parameter int unsigned APBX_CNT   = 4,
  parameter int unsigned APBX_PORTS = 16,
  parameter int unsigned AHBX_CNT   = 4,
  parameter int unsigned AHBX_PORTS = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           s_psel_i,
  input  logic                           s_penable_i,
  input  logic                           s_pwrite_i,
  input  logic [AW-1:0]                  s_paddr_i,
  input  logic [1:0]                     s_psize_i,
  input  logic [31:0]                    s_pwdata_i,
  output logic [31:0]                    s_prdata_o,
  output logic                           s_pready_o,
  output logic                           s_pslverr_o,
  input  logic                           ns_psel_i,
  input  logic                           ns_penable_i,
  input  logic                           ns_pwrite_i,
  input  logic [AW-1:0]                  ns_paddr_i,
  input  logic [1:0]                     ns_psize_i,
  input  logic [31:0]                    ns_pwdata_i,
  output logic [31:0]                    ns_prdata_o,
  output logic                           ns_pready_o,
  output logic                           ns_pslverr_o,
  output logic [APB_CNT*APB_PORTS-1:0]   apb_nonsec_o,
  output logic [APB_CNT*APB_PORTS-1:0]   apb_priv_o,
  output logic [APBX_CNT*APBX_PORTS-1:0] apbx_nonsec_o,
  output logic [APBX_CNT*APBX_PORTS-1:0] apbx_priv_o,
  output logic [AHBX_CNT*AHBX_PORTS-1:0] ahbx_nonsec_o,
  output logic [AHBX_CNT*AHBX_PORTS-1:0] ahbx_priv_o,
  output logic                           resp_cfg_o,
  output logic [1:0]                     nsc_cfg_o
);

  localparam int unsigned WAW = AW - 2;

  logic        s_wr, ns_wr, resp_hit, nsc_hit;
  logic        resp_q;
  logic [1:0]  nsc_q;
  logic [31:0] s_rd_apb, s_rd_apbx, s_rd_ahbx, s_rd_cfg, s_word;
  logic [31:0] ns_rd_apb, ns_rd_apbx, ns_rd_ahbx, ns_word;

  assign s_wr  = s_psel_i & s_penable_i & s_pwrite_i &
                 (s_psize_i == SZ_WORD) & (s_paddr_i[1:0] == 2'b00);
  assign ns_wr = ns_psel_i & ns_penable_i & ns_pwrite_i &
                 (ns_psize_i == SZ_WORD) & (ns_paddr_i[1:0] == 2'b00);

  assign resp_hit = s_paddr_i[AW-1:2] == WAW'(OFS_RESP >> 2);
  assign nsc_hit  = s_paddr_i[AW-1:2] == WAW'(OFS_NSC >> 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= 1'b0;
      nsc_q  <= 2'b00;
    end else begin
      if (s_wr && resp_hit) resp_q <= s_pwdata_i[0];
      if (s_wr && nsc_hit)  nsc_q  <= s_pwdata_i[1:0];
    end
  end

  assign resp_cfg_o = resp_q;
  assign nsc_cfg_o  = nsc_q;

  ppc_group #(
    .N(APB_CNT), .P(APB_PORTS), .AW(AW),
    .NS_SLOT(SLOT_APB_NS), .PV_SLOT(SLOT_APB_PV)
  ) u_apb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .s_we_i(s_wr), .s_addr_i(s_paddr_i), .s_wdata_i(s_pwdata_i),
    .ns_we_i(ns_wr), .ns_addr_i(ns_paddr_i), .ns_wdata_i(ns_pwdata_i),
    .s_rdata_o(s_rd_apb), .ns_rdata_o(ns_rd_apb),
    .nonsec_o(apb_nonsec_o), .priv_o(apb_priv_o)
  );

  ppc_group #(
    .N(APBX_CNT), .P(APBX_PORTS), .AW(AW),
    .NS_SLOT(SLOT_APBX_NS), .PV_SLOT(SLOT_APBX_PV)
  ) u_apbx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .s_we_i(s_wr), .s_addr_i(s_paddr_i), .s_wdata_i(s_pwdata_i),
    .ns_we_i(ns_wr), .ns_addr_i(ns_paddr_i), .ns_wdata_i(ns_pwdata_i),
    .s_rdata_o(s_rd_apbx), .ns_rdata_o(ns_rd_apbx),
    .nonsec_o(apbx_nonsec_o), .priv_o(apbx_priv_o)
  );

  ppc_group #(
    .N(AHBX_CNT), .P(AHBX_PORTS), .AW(AW),
    .NS_SLOT(SLOT_AHBX_NS), .PV_SLOT(SLOT_AHBX_PV)
  ) u_ahbx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .s_we_i(s_wr), .s_addr_i(s_paddr_i), .s_wdata_i(s_pwdata_i),
    .ns_we_i(ns_wr), .ns_addr_i(ns_paddr_i), .ns_wdata_i(ns_pwdata_i),
    .s_rdata_o(s_rd_ahbx), .ns_rdata_o(ns_rd_ahbx),
    .nonsec_o(ahbx_nonsec_o), .priv_o(ahbx_priv_o)
  );

  // each source is zero unless its decode hits, so OR merges them
  always_comb begin
    s_rd_cfg = '0;
    if (resp_hit) s_rd_cfg = {31'd0, resp_q};
    if (nsc_hit)  s_rd_cfg = {30'd0, nsc_q};
  end

  assign s_word  = s_rd_apb | s_rd_apbx | s_rd_ahbx | s_rd_cfg;
  assign ns_word = ns_rd_apb | ns_rd_apbx | ns_rd_ahbx;

  assign s_prdata_o   = lane_pick(s_word, s_paddr_i[1:0], s_psize_i);
  assign ns_prdata_o  = lane_pick(ns_word, ns_paddr_i[1:0], ns_psize_i);
  assign s_pready_o   = 1'b1;
  assign s_pslverr_o  = 1'b0;
  assign ns_pready_o  = 1'b1;
  assign ns_pslverr_o = 1'b0;

  p_narrow_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_psel_i && s_penable_i && s_pwrite_i && s_psize_i != SZ_WORD && !ns_wr)
    |=> $stable({apb_nonsec_o, apb_priv_o, apbx_nonsec_o, apbx_priv_o,
                 ahbx_nonsec_o, ahbx_priv_o, resp_cfg_o, nsc_cfg_o}));

  p_resp_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_wr && resp_hit) |=> resp_cfg_o == $past(s_pwdata_i[0]));

  p_nsc_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_wr && nsc_hit) |=> nsc_cfg_o == $past(s_pwdata_i[1:0]));

endmodule

// File: tb/ppc_perm_bank_tb.sv
module ppc_perm_bank_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        s_psel = 0, s_penable = 0, s_pwrite = 0;
  logic [11:0] s_paddr = '0;
  logic [1:0]  s_psize = 2'd2;
  logic [31:0] s_pwdata = '0;
  logic        ns_psel = 0, ns_penable = 0, ns_pwrite = 0;
  logic [11:0] ns_paddr = '0;
  logic [1:0]  ns_psize = 2'd2;
  logic [31:0] ns_pwdata = '0;
  logic [31:0] s_prdata, ns_prdata;
  logic        s_pready, s_pslverr, ns_pready, ns_pslverr;
  logic [7:0]  apb_nonsec, apb_priv;
  logic [63:0] apbx_nonsec, apbx_priv;
  logic [31:0] ahbx_nonsec, ahbx_priv;
  logic        resp_cfg;
  logic [1:0]  nsc_cfg;

  int n_chk = 0, n_fail = 0;

  logic [15:0] m_ns  [3][4];
  logic [15:0] m_sp  [3][4];
  logic [15:0] m_nsp [3][4];
  logic        m_resp;
  logic [1:0]  m_nsc;

  always #10 clk = ~clk;

  ppc_perm_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_psel_i(s_psel), .s_penable_i(s_penable), .s_pwrite_i(s_pwrite),
    .s_paddr_i(s_paddr), .s_psize_i(s_psize), .s_pwdata_i(s_pwdata),
    .s_prdata_o(s_prdata), .s_pready_o(s_pready), .s_pslverr_o(s_pslverr),
    .ns_psel_i(ns_psel), .ns_penable_i(ns_penable), .ns_pwrite_i(ns_pwrite),
    .ns_paddr_i(ns_paddr), .ns_psize_i(ns_psize), .ns_pwdata_i(ns_pwdata),
    .ns_prdata_o(ns_prdata), .ns_pready_o(ns_pready), .ns_pslverr_o(ns_pslverr),
    .apb_nonsec_o(apb_nonsec), .apb_priv_o(apb_priv),
    .apbx_nonsec_o(apbx_nonsec), .apbx_priv_o(apbx_priv),
    .ahbx_nonsec_o(ahbx_nonsec), .ahbx_priv_o(ahbx_priv),
    .resp_cfg_o(resp_cfg), .nsc_cfg_o(nsc_cfg)
  );

  // group 0 internal APB, 1 APB expansion, 2 AHB expansion
  function automatic int gn(input int g);
    return (g == 0) ? 2 : 4;
  endfunction
  function automatic int gp(input int g);
    return (g == 0) ? 4 : (g == 1) ? 16 : 8;
  endfunction
  function automatic int nsb(input int g);
    return (g == 0) ? 'h70 : (g == 1) ? 'h80 : 'h60;
  endfunction
  function automatic int pvb(input int g);
    return (g == 0) ? 'hB0 : (g == 1) ? 'hC0 : 'hA0;
  endfunction
  function automatic logic [15:0] pmask(input int g);
    return 16'((32'd1 << gp(g)) - 1);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int g = 0; g < 3; g++)
      for (int c = 0; c < 4; c++) begin
        m_ns[g][c] = '0; m_sp[g][c] = '0; m_nsp[g][c] = '0;
      end
    m_resp = 1'b0;
    m_nsc  = 2'b00;
  endtask

  task automatic m_write(input bit sec, input logic [11:0] a,
                         input logic [1:0] sz, input logic [31:0] d);
    if (sz != 2'd2 || a[1:0] != 2'b00) return;
    if (sec && a == 12'h010) m_resp = d[0];
    if (sec && a == 12'h014) m_nsc = d[1:0];
    for (int g = 0; g < 3; g++)
      for (int c = 0; c < gn(g); c++) begin
        if (sec && int'(a) == nsb(g) + 4*c) m_ns[g][c] = d[15:0] & pmask(g);
        if (sec && int'(a) == pvb(g) + 4*c) m_sp[g][c] = d[15:0] & pmask(g);
        if (!sec && int'(a) == pvb(g) + 4*c) m_nsp[g][c] = d[15:0] & pmask(g);
      end
  endtask

  function automatic logic [31:0] m_read(input bit sec, input logic [11:0] a,
                                         input logic [1:0] sz);
    logic [11:0] w;
    logic [31:0] r;
    w = {a[11:2], 2'b00};
    r = '0;
    if (sec && w == 12'h010) r = {31'd0, m_resp};
    if (sec && w == 12'h014) r = {30'd0, m_nsc};
    for (int g = 0; g < 3; g++)
      for (int c = 0; c < gn(g); c++) begin
        if (sec && int'(w) == nsb(g) + 4*c) r = {16'd0, m_ns[g][c]};
        if (sec && int'(w) == pvb(g) + 4*c) r = {16'd0, m_sp[g][c]};
        if (!sec && int'(w) == pvb(g) + 4*c) r = {16'd0, m_nsp[g][c]};
      end
    r = r >> (8 * int'(a[1:0]));
    if (sz == 2'd0) r = r & 32'hFF;
    else if (sz == 2'd1) r = r & 32'hFFFF;
    else r = r << (8 * int'(a[1:0])) | (r & 32'h0);
    if (sz[1]) r = m_read_word(sec, w);
    return r;
  endfunction

  function automatic logic [31:0] m_read_word(input bit sec, input logic [11:0] w);
    logic [31:0] r;
    r = '0;
    if (sec && w == 12'h010) r = {31'd0, m_resp};
    if (sec && w == 12'h014) r = {30'd0, m_nsc};
    for (int g = 0; g < 3; g++)
      for (int c = 0; c < gn(g); c++) begin
        if (sec && int'(w) == nsb(g) + 4*c) r = {16'd0, m_ns[g][c]};
        if (sec && int'(w) == pvb(g) + 4*c) r = {16'd0, m_sp[g][c]};
        if (!sec && int'(w) == pvb(g) + 4*c) r = {16'd0, m_nsp[g][c]};
      end
    return r;
  endfunction

  function automatic logic [63:0] exp_vec(input int g, input bit want_priv);
    logic [63:0] v;
    v = '0;
    for (int c = 0; c < gn(g); c++)
      for (int i = 0; i < gp(g); i++) begin
        if (!want_priv) v[c*gp(g)+i] = m_ns[g][c][i];
        else v[c*gp(g)+i] = m_ns[g][c][i] ? m_nsp[g][c][i] : m_sp[g][c][i];
      end
    return v;
  endfunction

  task automatic check_outputs(input string req);
    chk({req, " apb nonsec"},  64'(apb_nonsec),  exp_vec(0, 0));
    chk({req, " apb priv"},    64'(apb_priv),    exp_vec(0, 1));
    chk({req, " apbx nonsec"}, apbx_nonsec,      exp_vec(1, 0));
    chk({req, " apbx priv"},   apbx_priv,        exp_vec(1, 1));
    chk({req, " ahbx nonsec"}, 64'(ahbx_nonsec), exp_vec(2, 0));
    chk({req, " ahbx priv"},   64'(ahbx_priv),   exp_vec(2, 1));
    chk({req, " cfg"}, 64'({resp_cfg, nsc_cfg}), 64'({m_resp, m_nsc}));
  endtask

  task automatic bus(input bit sec, input bit wr, input logic [11:0] a,
                     input logic [1:0] sz, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    if (sec) begin
      s_psel = 1; s_penable = 0; s_pwrite = wr; s_paddr = a; s_psize = sz; s_pwdata = d;
    end else begin
      ns_psel = 1; ns_penable = 0; ns_pwrite = wr; ns_paddr = a; ns_psize = sz; ns_pwdata = d;
    end
    @(negedge clk);
    if (sec) s_penable = 1; else ns_penable = 1;
    #1;
    rd = sec ? s_prdata : ns_prdata;
    @(negedge clk);
    s_psel = 0; s_penable = 0; s_pwrite = 0;
    ns_psel = 0; ns_penable = 0; ns_pwrite = 0;
    if (wr) m_write(sec, a, sz, d);
    #1;
  endtask

  task automatic wr_w(input bit sec, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd;
    bus(sec, 1, a, 2'd2, d, rd);
  endtask

  task automatic rd_chk(input string req, input bit sec, input logic [11:0] a,
                        input logic [1:0] sz, input logic [31:0] exp);
    logic [31:0] rd;
    bus(sec, 0, a, sz, 32'h0, rd);
    chk(req, 64'(rd), 64'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    m_clear();
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    m_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;

    // R9 reset state
    check_outputs("R9");
    rd_chk("R9 s read", 1, 12'h070, 2'd2, 32'h0);
    rd_chk("R9 ns read", 0, 12'hB0, 2'd2, 32'h0);

    // R2 masking to 4 ports
    wr_w(1, 12'h070, 32'hFFFF_FFFF);
    rd_chk("R2 readback", 1, 12'h070, 2'd2, 32'h0000_000F);
    chk("R2 nonsec", 64'(apb_nonsec), 64'h0F);

    // R3 mask selection
    wr_w(1, 12'h0B0, 32'h5);
    wr_w(0, 12'h0B0, 32'hA);
    chk("R3 all nonsec", 64'(apb_priv[3:0]), 64'hA);
    wr_w(1, 12'h070, 32'h3);
    chk("R3 mixed", 64'(apb_priv[3:0]), 64'h6);
    check_outputs("R3");

    // R4 window separation
    rd_chk("R4 s mask", 1, 12'h0B0, 2'd2, 32'h5);
    rd_chk("R4 ns mask", 0, 12'h0B0, 2'd2, 32'hA);
    wr_w(0, 12'h070, 32'hFFFF_FFFF);
    wr_w(0, 12'h010, 32'h1);
    check_outputs("R4 ns blocked");
    rd_chk("R4 ns no enable view", 0, 12'h070, 2'd2, 32'h0);

    // R1 index decode
    wr_w(1, 12'h078, 32'hF);
    rd_chk("R1 absent index", 1, 12'h078, 2'd2, 32'h0);
    wr_w(1, 12'h08C, 32'h1234);
    chk("R1 apbx idx3", 64'(apbx_nonsec[63:48]), 64'h1234);
    wr_w(1, 12'h064, 32'hFFFF);
    chk("R1 ahbx idx1", 64'(ahbx_nonsec), 64'h0000_FF00);
    check_outputs("R1");

    // R5 narrow and unaligned writes
    bus(1, 1, 12'h080, 2'd0, 32'hFF, rd);
    bus(1, 1, 12'h081, 2'd2, 32'hFFFF, rd);
    bus(0, 1, 12'h0B4, 2'd1, 32'hFFFF, rd);
    bus(1, 1, 12'h010, 2'd3, 32'h1, rd);
    check_outputs("R5");
    rd_chk("R5 apbx0 untouched", 1, 12'h080, 2'd2, 32'h0);

    // R6 read lanes
    wr_w(1, 12'h080, 32'h0000_A5C3);
    rd_chk("R6 byte0", 1, 12'h080, 2'd0, 32'hC3);
    rd_chk("R6 byte1", 1, 12'h081, 2'd0, 32'hA5);
    rd_chk("R6 byte2", 1, 12'h082, 2'd0, 32'h00);
    rd_chk("R6 half1", 1, 12'h081, 2'd1, 32'hA5);
    rd_chk("R6 half2", 1, 12'h082, 2'd1, 32'h00);
    rd_chk("R6 word unaligned", 1, 12'h083, 2'd2, 32'hA5C3);

    // R7 configuration fields
    wr_w(1, 12'h010, 32'hFFFF_FFFF);
    wr_w(1, 12'h014, 32'hFFFF_FFFE);
    chk("R7 resp", 64'(resp_cfg), 64'h1);
    chk("R7 nsc", 64'(nsc_cfg), 64'h2);
    rd_chk("R7 resp read", 1, 12'h010, 2'd2, 32'h1);
    rd_chk("R7 nsc read", 1, 12'h014, 2'd2, 32'h2);

    // R8 internal AHB slots
    wr_w(1, 12'h050, 32'hFFFF_FFFF);
    wr_w(1, 12'h090, 32'hFFFF_FFFF);
    wr_w(0, 12'h090, 32'hFFFF_FFFF);
    rd_chk("R8 s 0x50", 1, 12'h050, 2'd2, 32'h0);
    rd_chk("R8 s 0x90", 1, 12'h090, 2'd2, 32'h0);
    rd_chk("R8 ns 0x90", 0, 12'h090, 2'd2, 32'h0);
    check_outputs("R8");

    // R10 unmapped and handshake
    wr_w(1, 12'hFFC, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped", 1, 12'h400, 2'd2, 32'h0);
    chk("R10 s ready/err", 64'({s_pready, s_pslverr}), 64'h2);
    chk("R10 ns ready/err", 64'({ns_pready, ns_pslverr}), 64'h2);
    check_outputs("R10");

    // random traffic
    for (int it = 0; it < 600; it++) begin
      bit sec, wr;
      logic [11:0] a;
      logic [1:0] sz;
      logic [31:0] d, exp;
      int g, c, pick;
      sec  = $urandom_range(0, 1);
      wr   = $urandom_range(0, 1);
      g    = $urandom_range(0, 2);
      c    = $urandom_range(0, 3);
      pick = $urandom_range(0, 9);
      if (pick < 4) a = 12'(nsb(g) + 4*c);
      else if (pick < 8) a = 12'(pvb(g) + 4*c);
      else if (pick == 8) a = 12'($urandom_range(4, 5) * 4);
      else a = 12'($urandom);
      if ($urandom_range(0, 9) < 2) a[1:0] = 2'($urandom);
      sz = ($urandom_range(0, 9) < 7) ? 2'd2 : 2'($urandom);
      d  = $urandom;
      exp = m_read(sec, a, sz);
      bus(sec, wr, a, sz, d, rd);
      if (!wr) chk("R6 random read", 64'(rd), 64'(exp));
      check_outputs("R3 random");
    end

    // R9 reset mid-run
    do_reset();
    check_outputs("R9 rerun");
    rd_chk("R9 nsp cleared", 0, 12'h0C0, 2'd2, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule